// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the main clock. It uses two dividers in series. A power-of-two prescaler divides the main clock by 2, 4, 8 or 16, selected by a 2-bit divide-select input. A half-period counter then counts BRG+1 prescaler ticks for each half of the serial clock period. One full serial clock period is therefore (2<<DIV) * 2 * (BRG+1) main-clock cycles. The fastest setting divides by 20 and the slowest divides by 2048.

The block never drives a derived clock net. It produces the serial clock level as a registered signal, together with two single-cycle strobes that the shift engine uses as clock enables. The leading strobe marks the move from the idle level to the active level. The trailing strobe marks the move back to idle. A polarity input chooses whether the idle level is low or high.

The divide settings and the polarity are captured only at period boundaries. Software can therefore change them while the clock runs without producing a short pulse. A rate value below 4 is raised to 4.

Top module: `spi_baud_gen`

## Requirements
- R1: With the block enabled, the half period is H = (2<<DIV) * (BRG+1) main-clock cycles. Counting the first rising clock edge that samples en_i high as edge 1, the leading strobe is high in the cycle after edge H, the trailing strobe after edge 2H, and the next leading strobe after edge 3H.
- R2: A brg_i value of 0 to 3 produces the same timing as brg_i = 4.
- R3: lead_o and trail_o are each high for exactly one cycle per event, they alternate, and they are never high together.
- R4: sclk_o sits at the idle level equal to the captured polarity (cpol 0 = idle low, cpol 1 = idle high). From a leading strobe until the next trailing strobe it sits at the inverted level, and it changes value in every cycle where lead_o is high.
- R5: The cycle after a clock edge that samples en_i low, sclk_o is at the idle level of cpol_i and both strobes are low, and they stay so while en_i is low. Enabling again restarts the timing of R1 from edge 1.
- R6: While enabled, changes on div_i, brg_i and cpol_i take effect only at the end of the current period. The active settings change only in a cycle where trail_o is high, and the next half period uses the new H.
- R7: While rst_n is low, the strobes are low and sclk_o equals cpol_i after the first clock edge. The divide settings present during reset become the active ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run enable; low holds both counters cleared |
| div_i | input | 2 | Prescaler select, divide by 2<<div_i |
| brg_i | input | 6 | Half-period tick count minus one, floored at 4 |
| cpol_i | input | 1 | Idle level of the serial clock |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe at the idle-to-active transition |
| trail_o | output | 1 | One-cycle strobe at the active-to-idle transition |

## Verification
A prescaler or half-period counter that wraps at the wrong value moves the first leading strobe away from cycle H. That error shows within one half period, which is at most 1024 cycles after enable. Phase state that is out of step shows as an inverted sclk_o level, or as two trailing strobes without a leading strobe between them, within one full period. Settings captured at the wrong moment make the trailing strobe fall at a time derived from the new H rather than the old one. That error is visible within the same period in which the change was made.

// File: rtl/spi_baud_pkg.sv
// Shared sizes and types for the SPI serial clock generator.
// Assumes the divide-select field picks a power-of-two prescale of 2<<div.
package spi_baud_pkg;
    localparam int DIV_W   = 2;   // prescaler select width
    localparam int BRG_W   = 6;   // half-period count width
    localparam int BRG_MIN = 4;   // smallest legal half-period count

    // Half of the serial clock period the generator is in
    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } baud_phase_e;
endpackage

// File: rtl/baud_cfg_hold.sv
// Holds the active divide settings and polarity. New values are taken while
// reset is low, while the generator is off, or at a period boundary.
// Assumes load is high only in those states. A rate below BRG_MIN is floored.
module baud_cfg_hold #(
    parameter int DIV_W   = spi_baud_pkg::DIV_W,
    parameter int BRG_W   = spi_baud_pkg::BRG_W,
    parameter int BRG_MIN = spi_baud_pkg::BRG_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_i,
    input  logic [BRG_W-1:0] brg_i,
    input  logic             cpol_i,
    output logic [DIV_W-1:0] div_a,
    output logic [BRG_W-1:0] brg_a,
    output logic             cpol_a
);
    localparam logic [BRG_W-1:0] FLOOR = BRG_W'(BRG_MIN);

    logic [BRG_W-1:0] brg_fix;

    // Raise an illegal small rate value to the floor
    always_comb begin
        brg_fix = (brg_i < FLOOR) ? FLOOR : brg_i;
    end

    // Capture settings in reset, when off, or at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            div_a  <= div_i;
            brg_a  <= brg_fix;
            cpol_a <= cpol_i;
        end
    end

    AST_BRG_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        brg_a >= FLOOR);  // R2
endmodule

// File: rtl/baud_prescaler.sv
// Power-of-two prescaler. It emits a one-cycle tick every 2<<div main clocks.
// Assumes div is held stable by the caller except at a period boundary, where
// the counter is already at its terminal value and wraps.
module baud_prescaler #(
    parameter  int DIV_W = spi_baud_pkg::DIV_W,
    localparam int PRE_W = 1 << DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [PRE_W-1:0] ONES = '1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] term;

    // Terminal count (2<<div)-1 as a right-shifted mask of ones
    always_comb begin
        term = ONES >> ((PRE_W - 1) - int'(div));
        tick = en && (cnt == term);
    end

    // Free-running count, cleared when off
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= PRE_W'(cnt + 1'b1);
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term);  // R1
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R1
endmodule

// File: rtl/baud_edge_gen.sv
// Half-period counter and phase register. After brg+1 prescaler ticks it
// toggles the phase and raises a registered strobe naming the transition.
// Assumes brg changes only at the boundary it reports or while off.
module baud_edge_gen #(
    parameter int BRG_W = spi_baud_pkg::BRG_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      tick,
    input  logic [BRG_W-1:0]          brg,
    output spi_baud_pkg::baud_phase_e phase,
    output logic                      lead,
    output logic                      trail,
    output logic                      boundary
);
    import spi_baud_pkg::*;

    logic [BRG_W-1:0] hcnt;
    logic             half_done;

    // End of a half period and end of a full period
    always_comb begin
        half_done = tick && (hcnt == brg);
        boundary  = half_done && (phase == PH_ACTIVE);
    end

    // Count ticks, toggle phase, register transition strobes
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            hcnt  <= '0;
            phase <= PH_IDLE;
            lead  <= 1'b0;
            trail <= 1'b0;
        end else begin
            lead  <= 1'b0;
            trail <= 1'b0;
            if (half_done) begin
                hcnt  <= '0;
                phase <= (phase == PH_IDLE) ? PH_ACTIVE : PH_IDLE;
                lead  <= (phase == PH_IDLE);
                trail <= (phase == PH_ACTIVE);
            end else if (tick) begin
                hcnt <= BRG_W'(hcnt + 1'b1);
            end
        end
    end

    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= brg);  // R1
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));  // R3
    AST_LEAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lead |=> !lead);  // R3
endmodule

// File: rtl/spi_baud_gen.sv
// SPI serial clock generator built from a power-of-two prescaler and a
// half-period counter. It gives the serial clock level and one-cycle
// leading/trailing strobes in the main clock domain.
// Assumes one main clock and a synchronous active-low reset.
module spi_baud_gen #(
    parameter int DIV_W   = spi_baud_pkg::DIV_W,
    parameter int BRG_W   = spi_baud_pkg::BRG_W,
    parameter int BRG_MIN = spi_baud_pkg::BRG_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [BRG_W-1:0] brg_i,
    input  logic             cpol_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o
);
    import spi_baud_pkg::*;

    logic [DIV_W-1:0] div_a;
    logic [BRG_W-1:0] brg_a;
    logic             cpol_a;
    logic             tick;
    logic             boundary;
    logic             cfg_load;
    baud_phase_e      phase;

    // Settings may move only when off or at the end of a period
    always_comb begin
        cfg_load = !en_i || boundary;
    end

    baud_cfg_hold #(.DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .div_i  (div_i),
        .brg_i  (brg_i),
        .cpol_i (cpol_i),
        .div_a  (div_a),
        .brg_a  (brg_a),
        .cpol_a (cpol_a)
    );

    baud_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_i),
        .div   (div_a),
        .tick  (tick)
    );

    baud_edge_gen #(.BRG_W(BRG_W)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_i),
        .tick     (tick),
        .brg      (brg_a),
        .phase    (phase),
        .lead     (lead_o),
        .trail    (trail_o),
        .boundary (boundary)
    );

    // Serial clock level is the phase seen through the polarity
    always_comb begin
        sclk_o = cpol_a ^ (phase == PH_ACTIVE);
    end

    AST_LEAD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lead_o |-> (sclk_o != $past(sclk_o)));  // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> (!lead_o && !trail_o && (sclk_o == cpol_a)));  // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_i) && !$stable({div_a, brg_a, cpol_a}))
        |-> trail_o);  // R6
endmodule

// File: tb/spi_baud_gen_test.sv
module spi_baud_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] div_i = '0;
    logic [5:0] brg_i = 6'd4;
    logic       cpol_i = 1'b1;
    logic       sclk_o, lead_o, trail_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    spi_baud_gen uut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_i(div_i),
        .brg_i(brg_i), .cpol_i(cpol_i),
        .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
    );

    // div, brg, cpol, expected half period
    localparam int VN = 6;
    localparam int VEC[VN][4] = '{
        '{0,  4, 0,   10},
        '{1, 10, 1,   44},
        '{3, 63, 0, 1024},
        '{2,  0, 1,   40},
        '{0,  3, 0,   10},
        '{2,  7, 1,   64}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setup_off(input int d, input int b, input int c);
        en_i = 1'b0; div_i = 2'(d); brg_i = 6'(b); cpol_i = 1'(c);
        cycle(); cycle();
    endtask

    task automatic run_case(input int d, input int b, input int c, input int h, input string tg);
        int fl = -1, sl = -1, ft = -1, nl = 0, nt = 0, act = -1, both = 0;
        setup_off(d, b, c);
        chk(sclk_o == 1'(c), "R4 idle level before enable", int'(sclk_o), c);
        en_i = 1'b1;
        for (int n = 1; n <= 3 * h + 2; n++) begin
            cycle();
            if (lead_o) begin
                nl++;
                if (fl < 0) fl = n; else if (sl < 0) sl = n;
            end
            if (trail_o) begin
                nt++;
                if (ft < 0) ft = n;
            end
            if (lead_o && trail_o) both = 1;
            if (n == h) act = int'(sclk_o);
        end
        chk(fl == h, {tg, " first leading strobe"}, fl, h);
        chk(ft == 2 * h, "R1 trailing strobe", ft, 2 * h);
        chk(sl == 3 * h, "R1 second leading strobe", sl, 3 * h);
        chk(nl == 2 && nt == 1 && both == 0, "R3 strobe count", nl * 10 + nt, 21);
        chk(act == (1 - c), "R4 active level", act, 1 - c);
        en_i = 1'b0;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int fl, ft;
        // R7: reset state
        cycle(); cycle();
        chk(sclk_o == 1'b1, "R7 reset sclk equals cpol", int'(sclk_o), 1);
        chk(!lead_o && !trail_o, "R7 reset strobes low", int'({lead_o, trail_o}), 0);
        rst_n = 1'b1;
        cycle();

        // R1/R2/R3/R4: vector table
        for (int i = 0; i < VN; i++) begin
            run_case(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                     (VEC[i][1] < 4) ? "R2" : "R1");
        end

        // R5: disable while active, then re-enable restarts timing
        setup_off(0, 4, 0);
        en_i = 1'b1;
        for (int n = 1; n <= 13; n++) cycle();
        chk(sclk_o == 1'b1, "R5 active before disable", int'(sclk_o), 1);
        en_i = 1'b0;
        cycle();
        chk(sclk_o == 1'b0, "R5 idle after disable", int'(sclk_o), 0);
        fl = 0;
        for (int n = 0; n < 40; n++) begin
            cycle();
            if (lead_o || trail_o || sclk_o) fl++;
        end
        chk(fl == 0, "R5 quiet while off", fl, 0);
        en_i = 1'b1;
        fl = -1;
        for (int n = 1; n <= 12; n++) begin
            cycle();
            if (lead_o && fl < 0) fl = n;
        end
        chk(fl == 10, "R5 restart from edge one", fl, 10);

        // R6: settings changed mid period take effect after the boundary
        setup_off(0, 4, 0);
        en_i = 1'b1;
        fl = -1; ft = -1;
        for (int n = 1; n <= 50; n++) begin
            cycle();
            if (n == 10) begin
                div_i = 2'd1; brg_i = 6'd5; cpol_i = 1'b1;  // new H = 24
            end
            if (trail_o && ft < 0) ft = n;
            if (lead_o && n > 10 && fl < 0) fl = n;
            if (n == 20) chk(sclk_o == 1'b1, "R6 new idle after boundary", int'(sclk_o), 1);
            if (n == 44) chk(sclk_o == 1'b0, "R6 new active level", int'(sclk_o), 0);
        end
        chk(ft == 20, "R6 old half period kept", ft, 20);
        chk(fl == 44, "R6 new half period used", fl, 44);
        en_i = 1'b0;
        cycle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule